// File: doc/BRIEF.md
# Local Interrupt Controller Mode Register

This block holds the 64-bit base and mode control word of a per-core local interrupt controller. The core writes the register through a single-cycle write strobe with a data word. Each write is screened against a legality table before anything is stored. The controller is in one of three operating states: OFF (unit disabled), LEGACY (enabled, memory-mapped programming model) and EXTENDED (enabled, register-based programming model with cluster-format logical addressing). The state is stored in the enable bit (bit 11) and the extended bit (bit 10). The base address field occupies bits 31:12. The boot-processor flag at bit 8 comes from a strap and is never changed by a write.

A legal write moves the state machine along one of its named transitions. ENABLE goes OFF to LEGACY. PROMOTE goes LEGACY to EXTENDED. REFRESH goes EXTENDED to EXTENDED. SHUTDOWN goes LEGACY or EXTENDED to OFF. HOLD leaves the state where it is. A legal write also loads the base field. An illegal write leaves every stored bit as it was and raises a one-cycle fault pulse. The illegal writes are DOWNGRADE (EXTENDED to LEGACY), SKIP (OFF straight to EXTENDED), a bad encoding, an unsupported extended request and reserved bits.

On PROMOTE or REFRESH the block derives a logical-destination word from the initial unit ID. Every write, accepted or not, reloads the working unit ID from the initial ID. A separate load port lets the memory-mapped window change the working ID between such writes.

Top module: `lic_mode_reg`

## Requirements
- R1: While reset is held and after it, the register reads base 0xFEE00, enable=1, extended=0 and bit 8 equal to the boot strap. Mode reads LEGACY (2'b10), fault reads 0, the logical destination reads 0 and the working ID equals the initial ID.
- R2: A write with any bit set in 63:32, in bit 9 or in bits 7:0 is rejected with a fault.
- R3: A write with bit 10 set while ext_supported is low is rejected with a fault.
- R4: A write with bit 11 clear and bit 10 set is an illegal encoding and is rejected with a fault.
- R5: A write requesting bits 11:10 = 2'b11 while the state is OFF (SKIP) is rejected with a fault.
- R6: A write requesting bits 11:10 = 2'b10 while the state is EXTENDED (DOWNGRADE) is rejected with a fault.
- R7: A rejected write leaves rd_data, mode and log_dest unchanged. It raises fault for exactly the one cycle after the write.
- R8: An accepted write loads bits 31:12 from the written word. Bit 8 keeps its stored value whatever is written there.
- R9: An accepted write with bit 11 clear (SHUTDOWN or HOLD in OFF) enters OFF with bits 11:10 = 0. It pulses sw_enable_clr for the one cycle after the write.
- R10: An accepted write with bit 11 set while OFF (ENABLE) enters LEGACY.
- R11: An accepted write with bits 11:10 = 2'b11 (PROMOTE or REFRESH) enters EXTENDED and sets log_dest to the low 32 bits of ((id & ~0xF) << 16) | (1 << id[3:0]), where id is init_id.
- R12: Any write, legal or not, sets cur_id to init_id. Otherwise id_load sets cur_id to id_load_val, and the register write wins when both occur in one cycle.
- R13: rd_data always shows the stored register, and mode always equals {rd_data[11], rd_data[10]}. Mode never shows 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 1 | Boot-processor flag loaded into bit 8 at reset |
| ext_supported | input | 1 | High when extended mode may be entered |
| init_id | input | 32 | Initial unit ID |
| wr_valid | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write value |
| id_load | input | 1 | Working-ID load strobe from the register window |
| id_load_val | input | 32 | Working-ID load value |
| rd_data | output | 64 | Current register value |
| mode | output | 2 | Current state as {enable, extended} |
| log_dest | output | 32 | Derived logical destination |
| cur_id | output | 32 | Working unit ID |
| fault | output | 1 | One-cycle pulse after a rejected write |
| sw_enable_clr | output | 1 | One-cycle pulse telling the spurious-vector logic to clear its software enable |

## Verification
A table of writes walks the state machine through every named transition, and each rejected write sits right next to a legal write that differs from it in only one bit or in the starting state. This separates a reserved-bit fault from a missing-support fault from a transition fault. Because the rejected writes carry a new base value, a fault that still stores the base shows up at once. Directed tests then cover the boot-flag bit, the one-cycle width of the pulses, two initial IDs whose derived destinations differ in both the cluster field and the one-hot field, and the working-ID load colliding with a register write.

// File: rtl/lic_pkg.sv
package lic_pkg;
    typedef enum logic [1:0] {
        LM_OFF    = 2'b00,
        LM_LEGACY = 2'b10,
        LM_EXT    = 2'b11
    } lic_mode_e;

    typedef enum logic [2:0] {
        CHK_OK        = 3'd0,
        CHK_RSVD      = 3'd1,
        CHK_NOSUP     = 3'd2,
        CHK_BADENC    = 3'd3,
        CHK_SKIP      = 3'd4,
        CHK_DOWNGRADE = 3'd5
    } lic_chk_e;
endpackage

// File: rtl/lic_xition_check.sv
module lic_xition_check
    import lic_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int BASE_LSB = 12,
    parameter int BASE_MSB = 31,
    parameter int EN_BIT   = 11,
    parameter int EXT_BIT  = 10,
    parameter int BSP_BIT  = 8
) (
    input  logic [DATA_W-1:0] wr_data,
    input  lic_mode_e         cur_mode,
    input  logic              ext_supported,
    output lic_chk_e          verdict
);
    function automatic logic [DATA_W-1:0] legal_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = BASE_LSB; i <= BASE_MSB; i++) m[i] = 1'b1;
        m[EN_BIT]  = 1'b1;
        m[EXT_BIT] = 1'b1;
        m[BSP_BIT] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] LEGAL_MASK = legal_mask();

    logic req_en, req_ext;
    assign req_en  = wr_data[EN_BIT];
    assign req_ext = wr_data[EXT_BIT];

    always_comb begin
        if (|(wr_data & ~LEGAL_MASK))
            verdict = CHK_RSVD;
        else if (req_ext && !ext_supported)
            verdict = CHK_NOSUP;
        else if (req_ext && !req_en)
            verdict = CHK_BADENC;
        else if (cur_mode == LM_OFF && req_en && req_ext)
            verdict = CHK_SKIP;
        else if (cur_mode == LM_EXT && req_en && !req_ext)
            verdict = CHK_DOWNGRADE;
        else
            verdict = CHK_OK;
    end
endmodule

// File: rtl/lic_ldest_gen.sv
module lic_ldest_gen #(
    parameter int ID_W = 32,
    parameter int LD_W = 32
) (
    input  logic [ID_W-1:0] id,
    output logic [LD_W-1:0] ldest
);
    localparam int WIDE_W = ID_W + 16;

    logic [WIDE_W-1:0] cluster_wide;
    logic [LD_W-1:0]   member_bit;

    assign cluster_wide = {id[ID_W-1:4], 4'b0000, 16'h0000};
    assign member_bit   = LD_W'(1) << id[3:0];
    assign ldest        = cluster_wide[LD_W-1:0] | member_bit;
endmodule

// File: rtl/lic_mode_reg.sv
module lic_mode_reg
    import lic_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ID_W       = 32,
    parameter int LD_W       = 32,
    parameter int BASE_LSB   = 12,
    parameter int BASE_MSB   = 31,
    parameter int EN_BIT     = 11,
    parameter int EXT_BIT    = 10,
    parameter int BSP_BIT    = 8,
    parameter logic [BASE_MSB-BASE_LSB:0] BASE_RESET = 20'hFEE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_strap,
    input  logic              ext_supported,
    input  logic [ID_W-1:0]   init_id,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              id_load,
    input  logic [ID_W-1:0]   id_load_val,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mode,
    output logic [LD_W-1:0]   log_dest,
    output logic [ID_W-1:0]   cur_id,
    output logic              fault,
    output logic              sw_enable_clr
);
    localparam int BASE_W = BASE_MSB - BASE_LSB + 1;

    lic_mode_e         state_q, state_d;
    logic [BASE_W-1:0] base_q, base_d;
    logic              bsp_q;
    logic [LD_W-1:0]   ldest_q, ldest_d, ldest_new;
    logic [ID_W-1:0]   id_q, id_d;
    logic              fault_q, fault_d, clr_q, clr_d;
    lic_chk_e          verdict;
    logic              accept, req_en, req_ext;

    lic_xition_check #(
        .DATA_W(DATA_W), .BASE_LSB(BASE_LSB), .BASE_MSB(BASE_MSB),
        .EN_BIT(EN_BIT), .EXT_BIT(EXT_BIT), .BSP_BIT(BSP_BIT)
    ) u_check (
        .wr_data      (wr_data),
        .cur_mode     (state_q),
        .ext_supported(ext_supported),
        .verdict      (verdict)
    );

    lic_ldest_gen #(.ID_W(ID_W), .LD_W(LD_W)) u_ldest (
        .id   (init_id),
        .ldest(ldest_new)
    );

    assign req_en  = wr_data[EN_BIT];
    assign req_ext = wr_data[EXT_BIT];
    assign accept  = wr_valid && (verdict == CHK_OK);

    // Next-state and next-value logic
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        ldest_d = ldest_q;
        fault_d = wr_valid && (verdict != CHK_OK);
        clr_d   = accept && !req_en;
        if (accept) begin
            base_d = wr_data[BASE_MSB:BASE_LSB];
            unique case (state_q)
                LM_OFF:    state_d = req_en  ? LM_LEGACY : LM_OFF;
                LM_LEGACY: state_d = !req_en ? LM_OFF : (req_ext ? LM_EXT : LM_LEGACY);
                LM_EXT:    state_d = !req_en ? LM_OFF : LM_EXT;
                default:   state_d = state_q;
            endcase
            if (req_en && req_ext)
                ldest_d = ldest_new;
        end
        if (wr_valid)
            id_d = init_id;
        else if (id_load)
            id_d = id_load_val;
        else
            id_d = id_q;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LM_LEGACY;
            base_q  <= BASE_RESET;
            bsp_q   <= boot_strap;
            ldest_q <= '0;
            id_q    <= init_id;
            fault_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            ldest_q <= ldest_d;
            id_q    <= id_d;
            fault_q <= fault_d;
            clr_q   <= clr_d;
        end
    end

    // Outputs
    always_comb begin
        rd_data                    = '0;
        rd_data[BASE_MSB:BASE_LSB] = base_q;
        rd_data[BSP_BIT]           = bsp_q;
        rd_data[EN_BIT]            = state_q[1];
        rd_data[EXT_BIT]           = state_q[0];
        mode                       = state_q;
        log_dest                   = ldest_q;
        cur_id                     = id_q;
        fault                      = fault_q;
        sw_enable_clr              = clr_q;
    end
endmodule

// File: rtl/lic_mode_reg_chk.sv
module lic_mode_reg_chk #(
    parameter int DATA_W   = 64,
    parameter int ID_W     = 32,
    parameter int LD_W     = 32,
    parameter int BASE_MSB = 31,
    parameter int EN_BIT   = 11,
    parameter int EXT_BIT  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_supported,
    input logic [ID_W-1:0]   init_id,
    input logic              wr_valid,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        mode,
    input logic [LD_W-1:0]   log_dest,
    input logic [ID_W-1:0]   cur_id,
    input logic              fault
);
    // R2
    upper_rsvd_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && |wr_data[DATA_W-1:BASE_MSB+1] |=> fault);
    // R3
    nosup_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_data[EXT_BIT] && !ext_supported |=> fault);
    // R4
    badenc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_data[EXT_BIT] && !wr_data[EN_BIT] |=> fault);
    // R5
    no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b11 |-> $past(mode) != 2'b00);
    // R6
    no_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == 2'b10 |-> $past(mode) != 2'b11);
    // R7
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> $past(wr_valid));
    // R7
    fault_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (rd_data == $past(rd_data)) && (log_dest == $past(log_dest)));
    // R12
    id_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid) |-> cur_id == $past(init_id));
    // R13
    mode_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode == {rd_data[EN_BIT], rd_data[EXT_BIT]} && mode != 2'b01);
endmodule

bind lic_mode_reg lic_mode_reg_chk #(
    .DATA_W(DATA_W), .ID_W(ID_W), .LD_W(LD_W),
    .BASE_MSB(BASE_MSB), .EN_BIT(EN_BIT), .EXT_BIT(EXT_BIT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_supported(ext_supported),
    .init_id      (init_id),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .mode         (mode),
    .log_dest     (log_dest),
    .cur_id       (cur_id),
    .fault        (fault)
);

// File: tb/lic_mode_reg_test.sv
module lic_mode_reg_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [63:0] wr;
        logic        sup;
        logic [63:0] rd;
        logic        flt;
        logic [1:0]  md;
        logic        clr;
    } vec_t;

    // Starting from reset (boot strap 0): rd 0xFEE00800, LEGACY
    localparam vec_t VECS [NV] = '{
        '{64'h1_FEE0_0800, 1'b1, 64'hFEE0_0800, 1'b1, 2'b10, 1'b0}, // R2 upper bits
        '{64'h0_1111_0A00, 1'b1, 64'hFEE0_0800, 1'b1, 2'b10, 1'b0}, // R2 bit 9
        '{64'h0_2222_0400, 1'b1, 64'hFEE0_0800, 1'b1, 2'b10, 1'b0}, // R4 en0 ext1
        '{64'h0_ABCD_E800, 1'b1, 64'hABCD_E800, 1'b0, 2'b10, 1'b0}, // R8 legal base
        '{64'h0_1234_5C00, 1'b0, 64'hABCD_E800, 1'b1, 2'b10, 1'b0}, // R3 no support
        '{64'h0_1234_5C00, 1'b1, 64'h1234_5C00, 1'b0, 2'b11, 1'b0}, // R11 promote
        '{64'h0_3333_3800, 1'b1, 64'h1234_5C00, 1'b1, 2'b11, 1'b0}, // R6 downgrade
        '{64'h0_1111_1C00, 1'b1, 64'h1111_1C00, 1'b0, 2'b11, 1'b0}, // R11 refresh
        '{64'h0_2222_2000, 1'b1, 64'h2222_2000, 1'b0, 2'b00, 1'b1}, // R9 shutdown
        '{64'h0_3333_3C00, 1'b1, 64'h2222_2000, 1'b1, 2'b00, 1'b0}, // R5 skip
        '{64'h0_4444_4000, 1'b1, 64'h4444_4000, 1'b0, 2'b00, 1'b1}, // R9 hold off
        '{64'h0_5555_5900, 1'b1, 64'h5555_5800, 1'b0, 2'b10, 1'b0}  // R10 enable, R8 bsp
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_strap = 1'b0;
    logic        ext_supported = 1'b1;
    logic [31:0] init_id = 32'h0000_1235;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        id_load = 1'b0;
    logic [31:0] id_load_val = '0;
    logic [63:0] rd_data;
    logic [1:0]  mode;
    logic [31:0] log_dest;
    logic [31:0] cur_id;
    logic        fault;
    logic        sw_enable_clr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lic_mode_reg uut (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
        .ext_supported(ext_supported), .init_id(init_id),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .id_load(id_load), .id_load_val(id_load_val),
        .rd_data(rd_data), .mode(mode), .log_dest(log_dest),
        .cur_id(cur_id), .fault(fault), .sw_enable_clr(sw_enable_clr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write at a falling edge; return at the next falling edge
    // with the strobe released, i.e. in the cycle after the write.
    task automatic do_write(input logic [63:0] v, input logic sup);
        @(negedge clk);
        wr_data = v;
        ext_supported = sup;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 rd in reset", rd_data, 64'hFEE0_0800);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rd", rd_data, 64'hFEE0_0800);
        check("R1 mode", 64'(mode), 64'h2);
        check("R1 fault", 64'(fault), 64'h0);
        check("R1 log_dest", 64'(log_dest), 64'h0);
        check("R1 cur_id", 64'(cur_id), 64'h1235);

        for (int i = 0; i < NV; i++) begin
            do_write(VECS[i].wr, VECS[i].sup);
            check($sformatf("R13 vec %0d rd", i), rd_data, VECS[i].rd);
            check($sformatf("R7 vec %0d fault", i), 64'(fault), 64'(VECS[i].flt));
            check($sformatf("R13 vec %0d mode", i), 64'(mode), 64'(VECS[i].md));
            check($sformatf("R9 vec %0d clr", i), 64'(sw_enable_clr), 64'(VECS[i].clr));
            if (i == 5 || i == 6 || i == 7)
                check($sformatf("R11 vec %0d log_dest", i), 64'(log_dest), 64'h1230_0020);
        end

        // R7: fault is one cycle wide
        do_write(64'h0_0000_0001, 1'b1);
        check("R7 fault pulse", 64'(fault), 64'h1);
        @(negedge clk);
        check("R7 fault drop", 64'(fault), 64'h0);
        check("R7 rd kept", rd_data, 64'h5555_5800);

        // R11: second ID, destination truncated to 32 bits
        init_id = 32'h0007_FFFF;
        do_write(64'h0_6666_6C00, 1'b1);
        check("R11 second id log_dest", 64'(log_dest), 64'hFFF0_8000);
        check("R12 write restores id", 64'(cur_id), 64'h7_FFFF);

        // R12: id load, then a rejected write restores, then collision
        @(negedge clk);
        id_load = 1'b1; id_load_val = 32'h99;
        @(negedge clk);
        id_load = 1'b0;
        check("R12 id load", 64'(cur_id), 64'h99);
        do_write(64'h0_6666_6800, 1'b1);
        check("R6 downgrade fault", 64'(fault), 64'h1);
        check("R12 restore on fault", 64'(cur_id), 64'h7_FFFF);
        @(negedge clk);
        id_load = 1'b1; id_load_val = 32'h55;
        wr_data = 64'h0_6666_6C00; wr_valid = 1'b1;
        @(negedge clk);
        id_load = 1'b0; wr_valid = 1'b0;
        check("R12 write beats load", 64'(cur_id), 64'h7_FFFF);

        // R1: reset with boot strap high
        boot_strap = 1'b1; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strap bsp", rd_data, 64'hFEE0_0900);
        // R8: writing bit 8 clear keeps the stored flag
        do_write(64'h0_7777_7800, 1'b1);
        check("R8 bsp kept", rd_data, 64'h7777_7900);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule